// File: doc/BRIEF.md
# Posted-Write Slow Bus Bridge

This bridge connects a fast replacement CPU to a slow, 8-bit legacy bus. A video chip shares that bus, so the CPU gets only one access slot in each slow cycle. The bridge decodes the top address bits of every CPU access into one of three cases. Most of the map goes only to fast local RAM. A shared-memory window goes to fast RAM and is also mirrored to the slow bus. A peripheral window lives only on the slow bus.

Writes bound for the slow bus go into a single-entry posted-write buffer, so the CPU keeps running at full clock rate. The buffer is written out in the next CPU slot. The CPU is stalled only in two cases: it needs the slow bus while the buffer is still occupied, or it reads the peripheral window. Peripheral reads are always real slow-bus cycles. They are aligned to a slot and sampled a programmable number of fast clocks after the slot opens.

Top module: `slowbus_bridge`

## Requirements
- R1: An access whose top four address bits are neither 0x1 nor 0x9 has `cpu_ready` high in the same cycle as `cpu_req`. It pulses `fram_en` and causes no slow-bus activity.
- R2: A write to 0x1xxx asserts `fram_en` and `fram_we` in its completing cycle. The same address and data later appear as one slow-bus write.
- R3: A read from 0x1xxx completes in its request cycle with `cpu_rdata` taken from `fram_rdata`. It causes no slow-bus cycle.
- R4: A write to 0x9xxx never asserts `fram_en` or `fram_we`. It produces exactly one slow-bus write with its address and data.
- R5: A write to either mapped window completes in its request cycle when no posted write is pending.
- R6: While a posted write is pending, any write to a mapped window and any 0x9xxx read is held off (`cpu_ready` low) until that write has finished on the slow bus.
- R7: A posted write starts on the first clock edge that sees `slow_phase` high after it was low. It drives `sb_act`=1, `sb_oe`=1 and `sb_rnw`=0, and holds `sb_addr`/`sb_dout` stable for SAMPLE_DLY+1 cycles.
- R8: A 0x9xxx read always stalls. It starts its slow cycle on a rising `slow_phase` edge and drives the CPU address with `sb_rnw`=1. It samples `sb_din` SAMPLE_DLY+1 edges after that start edge, and it raises `cpu_ready` with the sampled byte only after the slow cycle has ended.
- R9: Every 0x9xxx read produces exactly one slow-bus read. It is never answered from the write buffer or from earlier data.
- R10: Slow-bus accesses occur in program order. A pending posted write is drained before a following peripheral read starts.
- R11: When no slow access is active, `sb_act`=0, `sb_oe`=0 and `sb_rnw`=1. This is also the state from reset.
- R12: A CPU access completes on a rising clock edge where `cpu_req` and `cpu_ready` are both high. The request must be held with unchanged fields until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address, also fast RAM address |
| cpu_wdata | input | 8 | CPU write data, also fast RAM write data |
| cpu_rdata | output | 8 | Read data to CPU |
| cpu_ready | output | 1 | Access may complete this cycle |
| fram_en | output | 1 | Fast RAM access strobe |
| fram_we | output | 1 | Fast RAM write strobe |
| fram_rdata | input | 8 | Fast RAM read data (combinational) |
| slow_phase | input | 1 | High during the CPU half of each slow cycle |
| sb_act | output | 1 | Slow-bus access in progress |
| sb_addr | output | 16 | Slow-bus address |
| sb_dout | output | 8 | Slow-bus write data |
| sb_oe | output | 1 | Slow-bus data output enable |
| sb_rnw | output | 1 | Slow-bus direction, 1 = read |
| sb_din | input | 8 | Slow-bus read data |

## Verification
The assertions make three assumptions about the inputs. `slow_phase` is synchronous to `clk`. It stays high for more than SAMPLE_DLY+1 cycles in each slow cycle. The CPU holds a request unchanged until it is accepted. The bench generates `slow_phase` from a fixed eight-clock counter with a four-clock high half, which exceeds the three cycles used at the default delay. Every request is driven once at a falling edge and kept until the bench sees `cpu_ready`. The slow device returns valid data only at the intended sample cycle, and its peripheral reads carry a side effect, so a stale or early sample shows up as a wrong byte.

// File: rtl/slowbus_bridge.sv
module slowbus_bridge #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int DECODE_BITS = 4,
  parameter logic [AW-1:0] CHIP_BASE = 16'h1000,
  parameter logic [AW-1:0] IO_BASE = 16'h9000,
  parameter int SAMPLE_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          fram_en,
  output logic          fram_we,
  input  logic [DW-1:0] fram_rdata,
  input  logic          slow_phase,
  output logic          sb_act,
  output logic [AW-1:0] sb_addr,
  output logic [DW-1:0] sb_dout,
  output logic          sb_oe,
  output logic          sb_rnw,
  input  logic [DW-1:0] sb_din
);
  localparam int CW = $clog2(SAMPLE_DLY + 1) + 1;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} sb_state_t;

  sb_state_t     state;
  logic [CW-1:0] cnt;
  logic          phase_q;
  logic          buf_full;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;
  logic          rd_done;
  logic [DW-1:0] rd_data;

  wire in_chip    = cpu_addr[AW-1 -: DECODE_BITS] == CHIP_BASE[AW-1 -: DECODE_BITS];
  wire in_io      = cpu_addr[AW-1 -: DECODE_BITS] == IO_BASE[AW-1 -: DECODE_BITS];
  wire io_rd      = in_io & ~cpu_we;
  wire posted     = (in_chip | in_io) & cpu_we;
  wire slot_start = slow_phase & ~phase_q;
  wire last       = cnt == CW'(SAMPLE_DLY);

  assign cpu_ready = io_rd ? rd_done : (posted ? ~buf_full : 1'b1);
  wire   fire      = cpu_req & cpu_ready;
  assign fram_en   = fire & ~in_io;
  assign fram_we   = fram_en & cpu_we;
  assign cpu_rdata = io_rd ? rd_data : fram_rdata;

  assign sb_act = state != S_IDLE;
  assign sb_oe  = state == S_WR;
  assign sb_rnw = state != S_WR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      phase_q  <= 1'b1;
      buf_full <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
      sb_addr  <= '0;
      sb_dout  <= '0;
    end else begin
      phase_q <= slow_phase;
      if (fire && posted) begin
        buf_full <= 1'b1;
        buf_addr <= cpu_addr;
        buf_data <= cpu_wdata;
      end
      if (fire && io_rd) rd_done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (slot_start && buf_full) begin
            state   <= S_WR;
            sb_addr <= buf_addr;
            sb_dout <= buf_data;
          end else if (slot_start && cpu_req && io_rd && !rd_done) begin
            state   <= S_RD;
            sb_addr <= cpu_addr;
          end
        end
        S_WR: begin
          cnt <= cnt + CW'(1);
          if (last) begin
            state    <= S_IDLE;
            buf_full <= 1'b0;
          end
        end
        S_RD: begin
          cnt <= cnt + CW'(1);
          if (last) begin
            state   <= S_IDLE;
            rd_data <= sb_din;
            rd_done <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slowbus_bridge_chk.sv
module slowbus_bridge_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int DECODE_BITS = 4,
  parameter logic [AW-1:0] CHIP_BASE = 16'h1000,
  parameter logic [AW-1:0] IO_BASE = 16'h9000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_ready,
  input logic          fram_en,
  input logic          slow_phase,
  input logic          sb_act,
  input logic [AW-1:0] sb_addr,
  input logic [DW-1:0] sb_dout,
  input logic          sb_oe,
  input logic          sb_rnw
);
  wire chip = cpu_addr[AW-1 -: DECODE_BITS] == CHIP_BASE[AW-1 -: DECODE_BITS];
  wire io   = cpu_addr[AW-1 -: DECODE_BITS] == IO_BASE[AW-1 -: DECODE_BITS];

  p_fast_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !chip && !io |-> cpu_ready && fram_en);
  p_chip_read_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && chip && !cpu_we |-> cpu_ready && fram_en);
  p_io_no_fram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && io |-> !fram_en);
  p_stall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready && cpu_we && (chip || io)
    |=> !(cpu_req && cpu_ready && (cpu_we ? (chip || io) : io)));
  p_wr_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_oe) |-> slow_phase);
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sb_oe && $past(sb_oe) |-> $stable(sb_addr) && $stable(sb_dout));
  p_rd_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_act && sb_rnw) |-> slow_phase);
  p_rd_after_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && io && !cpu_we && cpu_ready |-> !sb_act);
  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_act |-> !sb_oe && sb_rnw);
endmodule

bind slowbus_bridge slowbus_bridge_chk #(
  .AW(AW), .DW(DW), .DECODE_BITS(DECODE_BITS), .CHIP_BASE(CHIP_BASE), .IO_BASE(IO_BASE)
) u_chk (.*);

// File: tb/test_slowbus_bridge.sv
module test_slowbus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata, fram_rdata, sb_din, sb_dout;
  logic        cpu_ready, fram_en, fram_we, sb_act, sb_oe, sb_rnw;
  logic        slow_phase = 1'b0;
  logic [15:0] sb_addr;

  always #2 clk = ~clk;

  slowbus_bridge i_slowbus_bridge (.*);

  int checks = 0, failures = 0;
  logic [7:0] fmem [256];
  logic [7:0] exp_fast [256];
  logic [7:0] dev [32];
  logic [7:0] exp_dev [32];
  logic [15:0] wq_a [1024];
  logic [7:0]  wq_d [1024];
  int wq_head = 0, wq_tail = 0;
  int pending = 0, slow_reads = 0, io_reads = 0;
  int ph_cnt = 4;
  logic prev_act = 1'b0, prev_oe = 1'b0;
  logic [15:0] cap_a;
  logic [7:0]  cap_d;
  int cycles = 0;

  function automatic logic [7:0] fidx(input logic [15:0] a);
    return {a[15:12], a[3:0]};
  endfunction
  function automatic logic [4:0] didx(input logic [15:0] a);
    return {a[15], a[3:0]};
  endfunction
  function automatic int kind(input logic [15:0] a);
    return (a[15:12] == 4'h1) ? 1 : (a[15:12] == 4'h9) ? 2 : 0;
  endfunction

  assign fram_rdata = fmem[fidx(cpu_addr)];
  assign sb_din = (ph_cnt == 3) ? dev[didx(sb_addr)] : ~dev[didx(sb_addr)];

  always @(posedge clk) if (fram_we) fmem[fidx(cpu_addr)] <= cpu_wdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sb_act && !prev_act) check(ph_cnt == 0, "R7/R8 slot start", ph_cnt, 0);
      if (!sb_act && prev_act) begin
        if (prev_oe) begin
          check(wq_head < wq_tail && cap_a == wq_a[wq_head] && cap_d == wq_d[wq_head],
                "R10 posted write order", {cap_a, cap_d}, {wq_a[wq_head], wq_d[wq_head]});
          dev[didx(cap_a)] = cap_d;
          wq_head++;
          pending--;
        end else begin
          dev[didx(cap_a)] = dev[didx(cap_a)] + 8'd1;
          slow_reads++;
        end
      end
      if (sb_act) begin cap_a = sb_addr; cap_d = sb_dout; end
      prev_act = sb_act;
      prev_oe  = sb_oe;
    end
    ph_cnt = (ph_cnt + 1) % 8;
    slow_phase = ph_cnt < 4;
  end

  task automatic do_op(input logic we, input logic [15:0] a, input logic [7:0] d);
    int waits = 0;
    int k = kind(a);
    int pend0;
    logic [7:0] got;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    pend0 = pending;
    while (!cpu_ready && waits < 100) begin
      @(negedge clk); #1; waits++;
    end
    if (waits >= 100) begin
      check(0, "R12 op timeout", waits, 0);
      cpu_req = 1'b0;
      return;
    end
    got = cpu_rdata;
    if (k == 0 || (k == 1 && !we)) check(waits == 0, "R1/R3 no stall", waits, 0);
    else if (we && pend0 == 0) check(waits == 0, "R5 posted write no stall", waits, 0);
    else if (we) check(waits > 0, "R6 stall while buffer full", waits, 1);
    else check(waits > 0, "R8 io read stalls", waits, 1);
    if (k == 2) check(!fram_en && !fram_we, "R4 no fast strobe on io", fram_en, 0);
    else check(fram_en && (fram_we == we), "R2 fast strobe", {fram_en, fram_we}, {1'b1, we});
    @(posedge clk);
    if (we) begin
      if (k != 2) exp_fast[fidx(a)] = d;
      if (k != 0) begin
        exp_dev[didx(a)] = d;
        wq_a[wq_tail] = a; wq_d[wq_tail] = d; wq_tail++;
        pending++;
      end
    end else if (k == 2) begin
      check(got == exp_dev[didx(a)], "R9 io read data", got, exp_dev[didx(a)]);
      exp_dev[didx(a)] = exp_dev[didx(a)] + 8'd1;
      io_reads++;
    end else begin
      check(got == exp_fast[fidx(a)], "R3 fast read data", got, exp_fast[fidx(a)]);
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired cycles=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [4];
    bases[0] = 16'h4000; bases[1] = 16'h1000; bases[2] = 16'h9000; bases[3] = 16'hC000;
    for (int i = 0; i < 256; i++) begin fmem[i] = 8'(i); exp_fast[i] = 8'(i); end
    for (int i = 0; i < 32; i++) begin dev[i] = 8'(i * 3); exp_dev[i] = 8'(i * 3); end
    void'($urandom(32'd20240607));
    repeat (5) @(negedge clk);
    check(!sb_act && !sb_oe && sb_rnw, "R11 reset idle bus", {sb_act, sb_oe, sb_rnw}, 3'b001);
    rst_n = 1'b1;
    do_op(1'b0, 16'h4003, 8'h00);
    do_op(1'b1, 16'h1002, 8'h5A);
    do_op(1'b0, 16'h1002, 8'h00);
    do_op(1'b1, 16'h9001, 8'h77);
    do_op(1'b1, 16'h9002, 8'h33);
    do_op(1'b0, 16'h9002, 8'h00);
    do_op(1'b1, 16'h9003, 8'hC4);
    do_op(1'b0, 16'h9003, 8'h00);
    do_op(1'b0, 16'h9003, 8'h00);
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a = bases[$urandom % 4] | 16'($urandom % 4);
      do_op(1'($urandom % 2), a, 8'($urandom));
    end
    repeat (40) @(negedge clk);
    check(pending == 0, "R6 buffer drained", pending, 0);
    check(slow_reads == io_reads, "R9 one slow read per io read", slow_reads, io_reads);
    check(!sb_act && !sb_oe && sb_rnw, "R11 idle bus", {sb_act, sb_oe, sb_rnw}, 3'b001);
    for (int i = 0; i < 32; i++)
      check(dev[i] == exp_dev[i], "R2/R4 slow bus contents", dev[i], exp_dev[i]);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule